// File: doc/BRIEF.md
# I2C Event Flag and Clock-Stretch Controller

This block gathers the event conditions reported by an I2C bus engine and keeps them as sticky flags in two status bytes. One summary bit, the event flag, is high while any sticky flag is set. The block drives an interrupt request through an interrupt-enable bit, and it tells the pad logic when SCL must be held low. The flags clear when software reads the status byte that holds them. A read that races with a new event returns the event and clears it. That event then raises no interrupt.

The bus engine supplies single-cycle event pulses and three live state levels: transmitter, bus busy and master. The host side supplies read strobes for both status bytes, a write port for the interrupt enable, the peripheral enable and the DMA state. The shift register, bit timing and pad drivers belong to other blocks.

Top module: `i2c_evt_ctl`

## Requirements
- R1: After a synchronous reset, every sticky flag, the event flag, the interrupt enable, `irq` and `scl_hold` are 0.
- R2: While `pe_en`=1, an event pulse shows in its status bit in the same cycle. The bit stays set in later cycles until a clearing read. With no read in that cycle, the event takes priority over any clear.
- R3: Status byte 1 has this bit layout: 7 event flag, 6 ten-bit header sent, 5 transmitter, 4 busy, 3 byte transfer finished, 2 addressed as slave, 1 master, 0 start sent. A cycle with `rd_sr1`=1 clears bits 6, 3, 2 and 0 at the next edge.
- R4: Status byte 2 has this bit layout: 0 acknowledge failure, 1 stop detected, 2 arbitration lost, 3 bus error, 4 address sent, and bits 7..5 always 0. A cycle with `rd_sr2`=1 clears bits 4..0 at the next edge.
- R5: Bits 5, 4 and 1 of status byte 1 always follow `tra_in`, `busy_in` and `msl_in`. Reads do not change them.
- R6: The event flag is 1 exactly when at least one sticky bit of either byte reads as 1. It stays 1 until every source has been cleared.
- R7: An address-match pulse while `ack_en`=0 is ignored.
- R8: While `pe_en`=0, events are ignored and all status flags read 0. At the next edge all flags and the interrupt enable clear, so `irq` stays 0 after re-enabling until software writes the enable again.
- R9: `irq` = `pe_en` AND interrupt enable AND (some flag held in the registers). A write with `ie_wr`=1 loads `ie_wdata`.
- R10: `scl_hold` is 1 while `pe_en`=1 and any held flag among start sent, addressed as slave, ten-bit header or address sent is set. It is also 1 when byte-finished is held with `dma_en`=0, or when `dma_en`=1, `dma_done`=0 and byte-finished is not held.
- R11: With `dma_en`=1 and byte-finished held as the only stretching flag, `scl_hold` is 0.
- R12: An event arriving in the same cycle as the read that clears it reads as 1 and is gone the next cycle, and `irq` does not rise for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pe_en | input | 1 | Peripheral enable |
| ie_wr | input | 1 | Interrupt-enable write strobe |
| ie_wdata | input | 1 | Interrupt-enable write value |
| ack_en | input | 1 | Acknowledge enable |
| dma_en | input | 1 | DMA enabled |
| dma_done | input | 1 | DMA transfer complete |
| ev_start | input | 1 | Start condition generated pulse |
| ev_slv_addr | input | 1 | Slave address matched pulse |
| ev_byte | input | 1 | Byte finished pulse |
| ev_hdr10 | input | 1 | Ten-bit header sent pulse |
| ev_addr_tx | input | 1 | Address sent (master) pulse |
| ev_nack | input | 1 | Acknowledge failure pulse |
| ev_stop | input | 1 | Stop detected pulse |
| ev_arb_lost | input | 1 | Arbitration lost pulse |
| ev_bus_err | input | 1 | Bus error pulse |
| tra_in | input | 1 | Live transmitter state |
| busy_in | input | 1 | Live bus-busy state |
| msl_in | input | 1 | Live master state |
| rd_sr1 | input | 1 | Status byte 1 read strobe |
| rd_sr2 | input | 1 | Status byte 2 read strobe |
| sr1 | output | 8 | Status byte 1 |
| sr2 | output | 8 | Status byte 2 |
| irq | output | 1 | Interrupt request |
| scl_hold | output | 1 | Request to hold SCL low |

## Verification
The bench targets several corner cases:
- An event landing in the same cycle as its clearing read. A design that let the clear lose would leave a stale flag and a spurious interrupt.
- Paired events split across the two status bytes. Here the event flag must survive the first read. A design that cleared it on any read would drop the second source.
- A byte-finished flag with DMA enabled. A wrong design would keep SCL stretched and stall the DMA.
- Disabling the peripheral. A design that kept the interrupt enable would fire as soon as the peripheral was re-enabled.

// File: rtl/i2c_evt_pkg.sv
package i2c_evt_pkg;
  localparam int SR_W   = 8;
  // group 1 (cleared by status byte 1 read)
  localparam int G1_N   = 4;
  localparam int G1_SB  = 0;
  localparam int G1_SLV = 1;
  localparam int G1_BTF = 2;
  localparam int G1_H10 = 3;
  // group 2 (cleared by status byte 2 read)
  localparam int G2_N   = 5;
  localparam int G2_AF  = 0;
  localparam int G2_STP = 1;
  localparam int G2_ARB = 2;
  localparam int G2_BER = 3;
  localparam int G2_ATX = 4;
endpackage

// File: rtl/i2c_evt_sticky.sv
module i2c_evt_sticky #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         clr,
  input  logic [N-1:0] ev,
  output logic [N-1:0] q,
  output logic [N-1:0] view
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst || !en)  q[i] <= 1'b0;
      else if (clr)    q[i] <= 1'b0;   // read wins: the racing event was shown in view
      else if (ev[i])  q[i] <= 1'b1;
    end
    assign view[i] = en & (q[i] | ev[i]);
  end
endmodule

// File: rtl/i2c_evt_hold.sv
module i2c_evt_hold (
  input  logic en,
  input  logic stall_src,
  input  logic btf,
  input  logic dma_en,
  input  logic dma_done,
  output logic hold
);
  logic btf_hold, dma_hold;
  always_comb begin
    btf_hold = btf & ~dma_en;
    dma_hold = dma_en & ~dma_done & ~btf;
    hold     = en & (stall_src | btf_hold | dma_hold);
  end
endmodule

// File: rtl/i2c_evt_irq.sv
module i2c_evt_irq (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic wr,
  input  logic wdata,
  input  logic any_flag,
  output logic irq
);
  logic ie_q;
  always_ff @(posedge clk) begin
    if (rst || !en) ie_q <= 1'b0;
    else if (wr)    ie_q <= wdata;
  end
  assign irq = en & ie_q & any_flag;
endmodule

// File: rtl/i2c_evt_ctl.sv
module i2c_evt_ctl
  import i2c_evt_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            pe_en,
  input  logic            ie_wr,
  input  logic            ie_wdata,
  input  logic            ack_en,
  input  logic            dma_en,
  input  logic            dma_done,
  input  logic            ev_start,
  input  logic            ev_slv_addr,
  input  logic            ev_byte,
  input  logic            ev_hdr10,
  input  logic            ev_addr_tx,
  input  logic            ev_nack,
  input  logic            ev_stop,
  input  logic            ev_arb_lost,
  input  logic            ev_bus_err,
  input  logic            tra_in,
  input  logic            busy_in,
  input  logic            msl_in,
  input  logic            rd_sr1,
  input  logic            rd_sr2,
  output logic [SR_W-1:0] sr1,
  output logic [SR_W-1:0] sr2,
  output logic            irq,
  output logic            scl_hold
);
  logic [G1_N-1:0] ev1, q1, v1;
  logic [G2_N-1:0] ev2, q2, v2;
  logic            evf_view, evf_held, stall_src;

  always_comb begin
    ev1          = '0;
    ev1[G1_SB]   = ev_start;
    ev1[G1_SLV]  = ev_slv_addr & ack_en;
    ev1[G1_BTF]  = ev_byte;
    ev1[G1_H10]  = ev_hdr10;
    ev2          = '0;
    ev2[G2_AF]   = ev_nack;
    ev2[G2_STP]  = ev_stop;
    ev2[G2_ARB]  = ev_arb_lost;
    ev2[G2_BER]  = ev_bus_err;
    ev2[G2_ATX]  = ev_addr_tx;
  end

  i2c_evt_sticky #(.N(G1_N)) u_g1 (
    .clk(clk), .rst(rst), .en(pe_en), .clr(rd_sr1), .ev(ev1), .q(q1), .view(v1)
  );
  i2c_evt_sticky #(.N(G2_N)) u_g2 (
    .clk(clk), .rst(rst), .en(pe_en), .clr(rd_sr2), .ev(ev2), .q(q2), .view(v2)
  );

  assign evf_view  = (|v1) | (|v2);
  assign evf_held  = (|q1) | (|q2);
  assign stall_src = q1[G1_SB] | q1[G1_SLV] | q1[G1_H10] | q2[G2_ATX];

  i2c_evt_hold u_hold (
    .en(pe_en), .stall_src(stall_src), .btf(q1[G1_BTF]),
    .dma_en(dma_en), .dma_done(dma_done), .hold(scl_hold)
  );

  i2c_evt_irq u_irq (
    .clk(clk), .rst(rst), .en(pe_en), .wr(ie_wr), .wdata(ie_wdata),
    .any_flag(evf_held), .irq(irq)
  );

  always_comb begin
    sr1 = {evf_view, v1[G1_H10], tra_in, busy_in, v1[G1_BTF], v1[G1_SLV], msl_in, v1[G1_SB]};
    sr2 = '0;
    sr2[G2_N-1:0] = v2;
  end
endmodule

// File: rtl/i2c_evt_ctl_chk.sv
module i2c_evt_ctl_chk (
  input logic       clk,
  input logic       rst,
  input logic       pe_en,
  input logic       ack_en,
  input logic       dma_en,
  input logic       ev_start,
  input logic       ev_slv_addr,
  input logic       ev_byte,
  input logic       ev_nack,
  input logic       rd_sr1,
  input logic       rd_sr2,
  input logic [7:0] sr1,
  input logic [7:0] sr2,
  input logic       irq,
  input logic       scl_hold
);
  a_r2_event_sticks: assert property (@(posedge clk) disable iff (rst)
    (pe_en && ev_start && !rd_sr1) |=> (sr1[0] || !pe_en));

  a_r3_sr1_read_clears: assert property (@(posedge clk) disable iff (rst)
    rd_sr1 |=> (sr1[3] == (pe_en && ev_byte)));

  a_r4_sr2_read_clears: assert property (@(posedge clk) disable iff (rst)
    rd_sr2 |=> (sr2[0] == (pe_en && ev_nack)));

  a_r6_evf_summary: assert property (@(posedge clk) disable iff (rst)
    !sr1[7] |-> (sr2[4:0] == 5'd0 && !sr1[6] && sr1[3:2] == 2'd0 && !sr1[0]));

  a_r7_slave_addr_gated: assert property (@(posedge clk) disable iff (rst)
    (!ack_en && ev_slv_addr && !sr1[2]) |=> (!sr1[2] || (ev_slv_addr && ack_en)));

  a_r8_disable_quiet: assert property (@(posedge clk) disable iff (rst)
    !pe_en |-> (!sr1[7] && !irq && !scl_hold));

  a_r8_disable_no_irq_next: assert property (@(posedge clk) disable iff (rst)
    !pe_en |=> !irq);

  a_r9_irq_needs_event: assert property (@(posedge clk) disable iff (rst)
    irq |-> sr1[7]);

  a_r10_start_stretches: assert property (@(posedge clk) disable iff (rst)
    (pe_en && ev_start && !rd_sr1) |=> (scl_hold || !pe_en));

  a_r11_dma_release: assert property (@(posedge clk) disable iff (rst)
    (pe_en && dma_en && sr1[3] && !ev_byte && !sr1[6] && !sr1[2] && !sr1[0] && !sr2[4])
      |-> !scl_hold);

  a_r12_race_no_irq: assert property (@(posedge clk) disable iff (rst)
    (rd_sr1 && rd_sr2) |=> !irq);
endmodule

bind i2c_evt_ctl i2c_evt_ctl_chk u_chk (
  .clk(clk), .rst(rst), .pe_en(pe_en), .ack_en(ack_en), .dma_en(dma_en),
  .ev_start(ev_start), .ev_slv_addr(ev_slv_addr), .ev_byte(ev_byte), .ev_nack(ev_nack),
  .rd_sr1(rd_sr1), .rd_sr2(rd_sr2), .sr1(sr1), .sr2(sr2), .irq(irq), .scl_hold(scl_hold)
);

// File: tb/i2c_evt_ctl_test.sv
module i2c_evt_ctl_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pe_en = 0, ie_wr = 0, ie_wdata = 0, ack_en = 1, dma_en = 0, dma_done = 1;
  logic ev_start = 0, ev_slv_addr = 0, ev_byte = 0, ev_hdr10 = 0, ev_addr_tx = 0;
  logic ev_nack = 0, ev_stop = 0, ev_arb_lost = 0, ev_bus_err = 0;
  logic tra_in = 0, busy_in = 0, msl_in = 0, rd_sr1 = 0, rd_sr2 = 0;
  logic [7:0] sr1, sr2;
  logic irq, scl_hold;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [7:0] o_sr1, o_sr2;
  logic o_irq, o_hold;

  // reference state: flags by name, plus interrupt enable
  bit m_sb, m_slv, m_btf, m_h10, m_atx, m_af, m_stp, m_arb, m_ber, m_ie;

  always #4 clk = ~clk;

  i2c_evt_ctl uut (
    .clk(clk), .rst(rst), .pe_en(pe_en), .ie_wr(ie_wr), .ie_wdata(ie_wdata),
    .ack_en(ack_en), .dma_en(dma_en), .dma_done(dma_done),
    .ev_start(ev_start), .ev_slv_addr(ev_slv_addr), .ev_byte(ev_byte), .ev_hdr10(ev_hdr10),
    .ev_addr_tx(ev_addr_tx), .ev_nack(ev_nack), .ev_stop(ev_stop), .ev_arb_lost(ev_arb_lost),
    .ev_bus_err(ev_bus_err), .tra_in(tra_in), .busy_in(busy_in), .msl_in(msl_in),
    .rd_sr1(rd_sr1), .rd_sr2(rd_sr2), .sr1(sr1), .sr2(sr2), .irq(irq), .scl_hold(scl_hold)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_compare();
    bit a_sb, a_slv, a_btf, a_h10, a_atx, a_af, a_stp, a_arb, a_ber, evf, held, hold;
    logic [7:0] e1, e2;
    a_sb  = pe_en && (m_sb  || ev_start);
    a_slv = pe_en && (m_slv || (ev_slv_addr && ack_en));
    a_btf = pe_en && (m_btf || ev_byte);
    a_h10 = pe_en && (m_h10 || ev_hdr10);
    a_atx = pe_en && (m_atx || ev_addr_tx);
    a_af  = pe_en && (m_af  || ev_nack);
    a_stp = pe_en && (m_stp || ev_stop);
    a_arb = pe_en && (m_arb || ev_arb_lost);
    a_ber = pe_en && (m_ber || ev_bus_err);
    evf = a_sb || a_slv || a_btf || a_h10 || a_atx || a_af || a_stp || a_arb || a_ber;
    held = m_sb || m_slv || m_btf || m_h10 || m_atx || m_af || m_stp || m_arb || m_ber;
    e1 = {evf, a_h10, tra_in, busy_in, a_btf, a_slv, msl_in, a_sb};
    e2 = {3'b000, a_atx, a_ber, a_arb, a_stp, a_af};
    if (!pe_en) hold = 0;
    else if (m_sb || m_slv || m_h10 || m_atx) hold = 1;
    else if (dma_en) hold = !dma_done && !m_btf;
    else hold = m_btf;
    check("R3 model sr1", sr1, e1);
    check("R4 model sr2", sr2, e2);
    check("R9 model irq", {7'd0, irq}, {7'd0, pe_en && m_ie && held});
    check("R10 model scl_hold", {7'd0, scl_hold}, {7'd0, hold});
  endtask

  task automatic model_update();
    if (rst || !pe_en) begin
      {m_sb, m_slv, m_btf, m_h10, m_atx, m_af, m_stp, m_arb, m_ber, m_ie} = '0;
    end else begin
      if (rd_sr1) {m_sb, m_slv, m_btf, m_h10} = '0;
      else begin
        m_sb  |= ev_start;  m_slv |= ev_slv_addr && ack_en;
        m_btf |= ev_byte;   m_h10 |= ev_hdr10;
      end
      if (rd_sr2) {m_atx, m_af, m_stp, m_arb, m_ber} = '0;
      else begin
        m_atx |= ev_addr_tx; m_af |= ev_nack; m_stp |= ev_stop;
        m_arb |= ev_arb_lost; m_ber |= ev_bus_err;
      end
      if (ie_wr) m_ie = ie_wdata;
    end
  endtask

  // inputs are set at the falling edge; one call = one clock
  task automatic step();
    #1;
    if (!rst) model_compare();
    o_sr1 = sr1; o_sr2 = sr2; o_irq = irq; o_hold = scl_hold;
    @(posedge clk);
    model_update();
    @(negedge clk);
    {ev_start, ev_slv_addr, ev_byte, ev_hdr10, ev_addr_tx} = '0;
    {ev_nack, ev_stop, ev_arb_lost, ev_bus_err} = '0;
    {rd_sr1, rd_sr2, ie_wr} = '0;
  endtask

  task automatic fire(input int idx);
    case (idx)
      0: ev_start = 1;    1: ev_slv_addr = 1; 2: ev_byte = 1;
      3: ev_hdr10 = 1;    4: ev_addr_tx = 1;  5: ev_nack = 1;
      6: ev_stop = 1;     7: ev_arb_lost = 1; default: ev_bus_err = 1;
    endcase
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    @(negedge clk);
    step(); step();
    rst = 0;
    step();
    check("R1 reset sr1", o_sr1, 8'h00);
    check("R1 reset sr2", o_sr2, 8'h00);
    check("R1 reset irq/hold", {6'd0, o_irq, o_hold}, 8'h00);

    pe_en = 1; ie_wr = 1; ie_wdata = 1; step();

    // each event alone, then read its byte
    for (int i = 0; i < 9; i++) begin
      fire(i); step();
      step();
      check("R2 flag held", {7'd0, o_sr1[7]}, 8'h01);
      check("R9 irq on event", {7'd0, o_irq}, 8'h01);
      if (i < 4) rd_sr1 = 1; else rd_sr2 = 1;
      step();
      step();
      check("R6 evf dropped after read", {7'd0, o_sr1[7]}, 8'h00);
      check(i < 4 ? "R3 sr1 cleared" : "R4 sr2 cleared",
            {o_sr1[6], o_sr1[3:2], o_sr1[0], o_sr2[4:0]}, 9'd0);
    end

    // pair across both bytes: evf survives first read
    ev_start = 1; ev_nack = 1; step();
    rd_sr1 = 1; step();
    step();
    check("R6 evf kept by other byte", {7'd0, o_sr1[7]}, 8'h01);
    check("R4 nack still set", {7'd0, o_sr2[0]}, 8'h01);
    rd_sr2 = 1; step(); step();
    check("R6 evf gone after both", {7'd0, o_sr1[7]}, 8'h00);

    // R7: slave match ignored with ack disabled
    ack_en = 0; ev_slv_addr = 1; step();
    check("R7 no same-cycle flag", {7'd0, o_sr1[2]}, 8'h00);
    step();
    check("R7 no flag held", {7'd0, o_sr1[7]}, 8'h00);
    ack_en = 1;

    // R12: event racing its clearing read
    ev_byte = 1; rd_sr1 = 1; step();
    check("R12 race reads as 1", {7'd0, o_sr1[3]}, 8'h01);
    step();
    check("R12 race cleared", {7'd0, o_sr1[3]}, 8'h00);
    check("R12 race no irq", {7'd0, o_irq}, 8'h00);

    // R10 / R11: stretching rules
    ev_start = 1; step(); step();
    check("R10 start stretches", {7'd0, o_hold}, 8'h01);
    rd_sr1 = 1; step(); step();
    check("R10 released after read", {7'd0, o_hold}, 8'h00);
    ev_byte = 1; step(); step();
    check("R10 byte without dma holds", {7'd0, o_hold}, 8'h01);
    dma_en = 1; dma_done = 0; step();
    check("R11 byte with dma releases", {7'd0, o_hold}, 8'h00);
    rd_sr1 = 1; step(); step();
    check("R10 dma pending holds", {7'd0, o_hold}, 8'h01);
    dma_done = 1; step();
    check("R10 dma done releases", {7'd0, o_hold}, 8'h00);
    dma_en = 0;

    // R5: live bits follow inputs, unaffected by reads
    tra_in = 1; busy_in = 1; msl_in = 1; rd_sr1 = 1; step();
    check("R5 live bits", o_sr1 & 8'h32, 8'h32);
    tra_in = 0; msl_in = 0; step();
    check("R5 live bits follow", o_sr1 & 8'h32, 8'h10);

    // R8: disable clears flags and interrupt enable
    ev_stop = 1; step();
    pe_en = 0; ev_arb_lost = 1; step();
    check("R8 disabled reads zero", {o_sr1[7], o_sr2[4:0]}, 6'd0);
    pe_en = 1; step();
    check("R8 flags cleared", {7'd0, o_sr1[7]}, 8'h00);
    ev_stop = 1; step(); step();
    check("R8 ie cleared, no irq", {7'd0, o_irq}, 8'h00);
    ie_wr = 1; ie_wdata = 1; step(); step();
    check("R9 irq after enable write", {7'd0, o_irq}, 8'h01);
    rd_sr2 = 1; step();

    // mixed traffic compared against the reference every clock
    lfsr = 16'hACE1;
    for (int n = 0; n < 3000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[3:0] == 4'h0) fire(lfsr[7:4] % 9);
      if (lfsr[4:1] == 4'h5) fire(lfsr[11:8] % 9);
      rd_sr1   = (lfsr[9:7] == 3'b101);
      rd_sr2   = (lfsr[12:10] == 3'b011);
      ack_en   = lfsr[13] | lfsr[2];
      dma_en   = lfsr[14] & lfsr[6];
      dma_done = lfsr[15] | lfsr[5];
      tra_in   = lfsr[1]; busy_in = lfsr[8]; msl_in = lfsr[12];
      pe_en    = (lfsr[15:11] != 5'h1F);
      if (lfsr[10:6] == 5'h11) begin ie_wr = 1; ie_wdata = 1; end
      step();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule